// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block computes a single-error-correcting parity code over a data sector that arrives one byte per clock. Every set data bit has a bit position inside the sector: byte index times eight plus the bit number inside the byte. For each bit of that position number the block keeps two parity bits. The "ones" parity collects the data bits whose position has that bit set. The "zeros" parity collects the data bits whose position has it clear. The two halves are packed with the ones half on top and the zeros half below, and the packed word is inverted. As a result, an erased sector of all-ones bytes produces an all-ones code, which matches what an erased spare area holds.

To write, software streams the sector and stores `code_out`. To read, it streams the sector again, presents the stored code, and pulses `check_stb`. The block XORs the fresh code with the stored one and classifies the difference as one of four outcomes:
- clean;
- a single flipped data bit, reported with the byte index and the bit mask to apply;
- a single flipped bit inside the stored code itself, which needs no data change;
- uncorrectable.

A sequencer with three states controls the block:
- `ST_IDLE` is the state after reset. It waits for a start pulse.
- `ST_ACCUM` counts accepted bytes.
- `ST_READY` holds a finished code and accepts checks.

The transitions are:
- IDLE→ACCUM on `sos`.
- ACCUM→READY when the last byte of the sector is accepted.
- ACCUM→ACCUM on a new `sos`, which restarts the sector.
- READY→ACCUM on `sos`.

Every other case holds the current state.

Top module: `hecc_sector_top`

## Requirements
- R1: After the last of SECTOR_BYTES accepted bytes, `code_valid` is 1 from the next cycle on. `code_out` equals the bitwise inverse of {P1, P0}:
  - P1 (bits 23:12 at the default size) is the XOR of the 12-bit positions of all set data bits.
  - P0 (bits 11:0) is the XOR of the complements of those positions.
- R2: With the default 512-byte sector, a sector of all 0xFF bytes gives `code_out` = 0xFFFFFF.
- R3: `sos` clears the accumulation and counts its own byte (if `byte_valid`) as byte 0. A `sos` in the middle of a sector restarts it, and `code_valid` is 0 in the cycle after `sos`.
- R4: Cycles with `byte_valid` low do not change the code. Bytes that arrive after the sector completes and before the next `sos` are ignored, and `code_out` stays stable.
- R5: A `check_stb` in READY gives `res_valid` = 1 in the next cycle. The difference is `code_out` XOR `stored_code`. A zero difference gives `res_kind` = 0 (clean).
- R6: If the upper half XOR the lower half of the difference is all ones, the result is a data error with `res_kind` = 1:
  - `err_byte` is difference bits 23:15.
  - `err_mask` is a one-hot mask at difference bits 14:12.
- R7: A data-error pattern whose byte index is not below SECTOR_BYTES gives `res_kind` = 3, with `err_byte` and `err_mask` zero.
- R8: A difference with exactly one bit set gives `res_kind` = 2 (error in the code), with `err_byte` and `err_mask` zero.
- R9: Any other nonzero difference gives `res_kind` = 3, with `err_byte` and `err_mask` zero.
- R10: A `check_stb` outside READY produces no `res_valid`.
- R11: After reset, `code_valid` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sos | input | 1 | Start of sector; the byte in this cycle is byte 0 |
| byte_valid | input | 1 | `byte_data` carries a sector byte |
| byte_data | input | 8 | Sector byte |
| stored_code | input | CODE_W (24) | Code read back from storage |
| check_stb | input | 1 | Compare `stored_code` against the computed code |
| code_out | output | CODE_W (24) | Inverted packed parity code |
| code_valid | output | 1 | `code_out` is complete (READY state) |
| res_valid | output | 1 | One-cycle pulse: a classification is presented |
| res_kind | output | 2 | 0 clean, 1 data bit, 2 code bit, 3 uncorrectable |
| err_byte | output | ABITS (9) | Byte index of the flipped data bit |
| err_mask | output | 8 | Bit mask to XOR into that byte |

## Verification
The hardest outcome to reach from the ports is a data-error pattern at every one of the 4096 bit positions. Reaching each one by flipping streamed data would cost a full sector per position. Instead, the bench streams one known sector and then offsets `stored_code` by the exact difference that each position would produce, so the classifier sees all positions in two cycles each. A second instance with a 300-byte sector shares the same stimulus. It reaches the out-of-range index case, which cannot occur at a power-of-two size. A few real flips of streamed data confirm the end-to-end path.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_READY = 2'd2
    } hecc_state_e;

    localparam logic [1:0] RES_CLEAN  = 2'd0;
    localparam logic [1:0] RES_DATA   = 2'd1;
    localparam logic [1:0] RES_CODE   = 2'd2;
    localparam logic [1:0] RES_UNCORR = 2'd3;

    // Column selector: bit b of the result is bit k of b.
    function automatic logic [7:0] col_mask(input int k);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hecc_parity_acc.sv
module hecc_parity_acc #(
    parameter int ABITS = 9,
    localparam int HALF = ABITS + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [ABITS-1:0] addr,
    input  logic [7:0]       data,
    output logic [HALF-1:0]  ones,
    output logic [HALF-1:0]  zeros
);
    logic [HALF-1:0] c_one;
    logic [HALF-1:0] c_zero;
    logic            byte_par;

    assign byte_par = ^data;

    genvar k;
    generate
        for (k = 0; k < HALF; k++) begin : g_col
            if (k < 3) begin : g_bit
                localparam logic [7:0] SEL = hecc_pkg::col_mask(k);
                assign c_one[k]  = ^(data & SEL);
                assign c_zero[k] = ^(data & ~SEL);
            end else begin : g_addr
                assign c_one[k]  = addr[k-3] & byte_par;
                assign c_zero[k] = ~addr[k-3] & byte_par;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones  <= '0;
            zeros <= '0;
        end else if (clear) begin
            ones  <= en ? c_one  : '0;
            zeros <= en ? c_zero : '0;
        end else if (en) begin
            ones  <= ones  ^ c_one;
            zeros <= zeros ^ c_zero;
        end
    end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify #(
    parameter int SECTOR_BYTES = 512,
    parameter int ABITS = 9,
    localparam int HALF = ABITS + 3,
    localparam int CODE_W = 2 * HALF
) (
    input  logic [CODE_W-1:0] computed,
    input  logic [CODE_W-1:0] stored,
    output logic [1:0]        kind,
    output logic [ABITS-1:0]  byte_idx,
    output logic [7:0]        bit_mask
);
    import hecc_pkg::*;

    logic [CODE_W-1:0] diff;
    logic [HALF-1:0]   hi;
    logic [HALF-1:0]   lo;
    logic [ABITS-1:0]  idx;
    logic              in_range;
    logic              paired;
    logic              single;

    assign diff   = computed ^ stored;
    assign hi     = diff[CODE_W-1:HALF];
    assign lo     = diff[HALF-1:0];
    assign idx    = hi[HALF-1:3];
    assign paired = (hi ^ lo) == {HALF{1'b1}};
    assign single = $countones(diff) == 1;

    generate
        if (SECTOR_BYTES == (1 << ABITS)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = {{(32-ABITS){1'b0}}, idx} < SECTOR_BYTES;
        end
    endgenerate

    always_comb begin
        kind     = RES_UNCORR;
        byte_idx = '0;
        bit_mask = '0;
        if (diff == '0) begin
            kind = RES_CLEAN;
        end else if (paired) begin
            if (in_range) begin
                kind     = RES_DATA;
                byte_idx = idx;
                bit_mask = 8'd1 << hi[2:0];
            end
        end else if (single) begin
            kind = RES_CODE;
        end
    end
endmodule

// File: rtl/hecc_sector_top.sv
module hecc_sector_top #(
    parameter int SECTOR_BYTES = 512,
    localparam int ABITS = $clog2(SECTOR_BYTES),
    localparam int HALF = ABITS + 3,
    localparam int CODE_W = 2 * HALF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sos,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [CODE_W-1:0] stored_code,
    input  logic              check_stb,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [ABITS-1:0]  err_byte,
    output logic [7:0]        err_mask
);
    import hecc_pkg::*;

    localparam logic [ABITS-1:0] CNT_LAST = ABITS'(SECTOR_BYTES - 1);

    hecc_state_e      state;
    hecc_state_e      state_nx;
    logic [ABITS-1:0] cnt;
    logic             accept;
    logic             last_byte;
    logic [ABITS-1:0] acc_addr;
    logic [HALF-1:0]  p_one;
    logic [HALF-1:0]  p_zero;
    logic [1:0]       kind_c;
    logic [ABITS-1:0] byte_c;
    logic [7:0]       mask_c;

    assign accept    = byte_valid && (sos || state == ST_ACCUM);
    assign last_byte = cnt == CNT_LAST;
    assign acc_addr  = sos ? '0 : cnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (sos) begin
            state_nx = ST_ACCUM;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ACCUM: if (byte_valid && last_byte) state_nx = ST_READY;
                ST_READY: state_nx = ST_READY;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // Byte counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sos) begin
            cnt <= byte_valid ? ABITS'(1) : '0;
        end else if (accept) begin
            cnt <= cnt + ABITS'(1);
        end
    end

    hecc_parity_acc #(.ABITS(ABITS)) acc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sos),
        .en    (accept),
        .addr  (acc_addr),
        .data  (byte_data),
        .ones  (p_one),
        .zeros (p_zero)
    );

    hecc_classify #(.SECTOR_BYTES(SECTOR_BYTES), .ABITS(ABITS)) cls_i (
        .computed (code_out),
        .stored   (stored_code),
        .kind     (kind_c),
        .byte_idx (byte_c),
        .bit_mask (mask_c)
    );

    // Outputs derived from state
    always_comb begin
        code_out   = ~{p_one, p_zero};
        code_valid = state == ST_READY;
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_kind  <= RES_CLEAN;
            err_byte  <= '0;
            err_mask  <= '0;
        end else begin
            res_valid <= check_stb && state == ST_READY;
            if (check_stb && state == ST_READY) begin
                res_kind <= kind_c;
                err_byte <= byte_c;
                err_mask <= mask_c;
            end
        end
    end
endmodule

// File: rtl/hecc_sector_chk.sv
module hecc_sector_chk #(
    parameter int CODE_W = 24,
    parameter int ABITS = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sos,
    input logic              check_stb,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid,
    input logic              res_valid,
    input logic [1:0]        res_kind,
    input logic [ABITS-1:0]  err_byte,
    input logic [7:0]        err_mask
);
    a_r4_code_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && !sos |=> code_valid);

    a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && !sos |=> $stable(code_out));

    a_r3_sos_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        sos |=> !code_valid);

    a_r10_result_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(check_stb) && $past(code_valid));

    a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_kind == 2'd1 |-> $countones(err_mask) == 1);

    a_r9_no_flip_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_kind != 2'd1 |-> err_mask == 8'd0 && err_byte == '0);
endmodule

bind hecc_sector_top hecc_sector_chk #(.CODE_W(CODE_W), .ABITS(ABITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sos        (sos),
    .check_stb  (check_stb),
    .code_out   (code_out),
    .code_valid (code_valid),
    .res_valid  (res_valid),
    .res_kind   (res_kind),
    .err_byte   (err_byte),
    .err_mask   (err_mask)
);

// File: tb/hecc_sector_top_tb_top.sv
module hecc_sector_top_tb_top;

    localparam int NA = 512;
    localparam int NB = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sos = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        check_stb = 1'b0;
    logic [23:0] stored_a = '0;
    logic [23:0] stored_b = '0;

    logic [23:0] code_a, code_b;
    logic        cv_a, cv_b, rv_a, rv_b;
    logic [1:0]  kind_a, kind_b;
    logic [8:0]  eb_a, eb_b;
    logic [7:0]  em_a, em_b;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] mem [0:519];

    always #2.5 clk = ~clk;

    hecc_sector_top dut_i (
        .clk(clk), .rst_n(rst_n), .sos(sos), .byte_valid(byte_valid),
        .byte_data(byte_data), .stored_code(stored_a), .check_stb(check_stb),
        .code_out(code_a), .code_valid(cv_a), .res_valid(rv_a),
        .res_kind(kind_a), .err_byte(eb_a), .err_mask(em_a)
    );

    hecc_sector_top #(.SECTOR_BYTES(NB)) dut_s (
        .clk(clk), .rst_n(rst_n), .sos(sos), .byte_valid(byte_valid),
        .byte_data(byte_data), .stored_code(stored_b), .check_stb(check_stb),
        .code_out(code_b), .code_valid(cv_b), .res_valid(rv_b),
        .res_kind(kind_b), .err_byte(eb_b), .err_mask(em_b)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code(input int n, input int fb, input int fbit);
        logic [11:0] p1 = '0;
        int ones = 0;
        for (int a = 0; a < n; a++) begin
            logic [7:0] d = mem[a];
            if (a == fb) d = d ^ (8'd1 << fbit);
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    p1 = p1 ^ 12'(a * 8 + b);
                    ones++;
                end
            end
        end
        return ~{p1, p1 ^ ((ones % 2 == 1) ? 12'hFFF : 12'h000)};
    endfunction

    task automatic stream(input int n, input int fb, input int fbit, input bit gaps, input int chk_at);
        for (int a = 0; a < n; a++) begin
            @(negedge clk);
            if (a == chk_at + 1) begin
                expect_eq("R10 check outside READY (a)", 32'(rv_a), 32'd0);
                expect_eq("R10 check outside READY (b)", 32'(rv_b), 32'd0);
            end
            sos        = (a == 0);
            byte_valid = 1'b1;
            byte_data  = (a == fb) ? (mem[a] ^ (8'd1 << fbit)) : mem[a];
            check_stb  = (a == chk_at);
            if (gaps && (a % 3 == 1)) begin
                @(negedge clk);
                sos        = 1'b0;
                byte_valid = 1'b0;
                check_stb  = 1'b0;
                byte_data  = 8'h5A;
            end
        end
        @(negedge clk);
        sos        = 1'b0;
        byte_valid = 1'b0;
        check_stb  = 1'b0;
    endtask

    task automatic do_check(input logic [23:0] sa, input logic [23:0] sb);
        @(negedge clk);
        stored_a  = sa;
        stored_b  = sb;
        check_stb = 1'b1;
        @(negedge clk);
        check_stb = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] ca, cb, diff;
        logic [11:0] p;

        repeat (4) @(negedge clk);
        expect_eq("R11 reset code_valid a", 32'(cv_a), 32'd0);
        expect_eq("R11 reset code_valid b", 32'(cv_b), 32'd0);
        expect_eq("R11 reset res_valid a", 32'(rv_a), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R11 idle after reset", 32'(cv_a), 32'd0);

        // Erased sector
        for (int a = 0; a < 520; a++) mem[a] = 8'hFF;
        stream(NA, -1, 0, 1'b0, -5);
        expect_eq("R1 code_valid after sector", 32'(cv_a), 32'd1);
        expect_eq("R2 erased code", 32'(code_a), 32'hFFFFFF);
        expect_eq("R1 small code_valid", 32'(cv_b), 32'd1);
        expect_eq("R1 small erased code", 32'(code_b), 32'(model_code(NB, -1, 0)));
        do_check(24'hFFFFFF, model_code(NB, -1, 0));
        expect_eq("R5 res_valid", 32'(rv_a), 32'd1);
        expect_eq("R5 erased clean", 32'(kind_a), 32'd0);
        expect_eq("R5 small clean", 32'(kind_b), 32'd0);
        @(negedge clk);
        expect_eq("R5 res_valid one pulse", 32'(rv_a), 32'd0);

        // Patterned sector with gaps; also 8 extra bytes for the 512 instance
        for (int a = 0; a < 520; a++) mem[a] = 8'(a * 37 + 11) ^ 8'(a >> 3);
        ca = model_code(NA, -1, 0);
        cb = model_code(NB, -1, 0);
        stream(520, -1, 0, 1'b1, -5);
        expect_eq("R1 R4 pattern code with gaps, extras ignored", 32'(code_a), 32'(ca));
        expect_eq("R4 small ignores bytes after sector", 32'(code_b), 32'(cb));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = 8'(i * 29 + 1);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        @(negedge clk);
        expect_eq("R4 code held in READY", 32'(code_a), 32'(ca));
        do_check(ca, cb);
        expect_eq("R5 pattern clean", 32'(kind_a), 32'd0);

        // Sweep over every data-bit position
        for (int i = 0; i < 4096; i++) begin
            p = 12'(i);
            diff = {p, ~p};
            do_check(ca ^ diff, cb ^ diff);
            expect_eq("R6 sweep kind", 32'(kind_a), 32'd1);
            expect_eq("R6 sweep byte", 32'(eb_a), 32'(i >> 3));
            expect_eq("R6 sweep mask", 32'(em_a), 32'(8'd1 << (i % 8)));
            if ((i >> 3) < NB) begin
                expect_eq("R6 small sweep kind", 32'(kind_b), 32'd1);
                expect_eq("R6 small sweep byte", 32'(eb_b), 32'(i >> 3));
            end else begin
                expect_eq("R7 out-of-range kind", 32'(kind_b), 32'd3);
                expect_eq("R7 out-of-range no flip", 32'({eb_b, em_b}), 32'd0);
            end
        end

        // Single bit in the code
        for (int i = 0; i < 24; i++) begin
            diff = 24'd1 << i;
            do_check(ca ^ diff, cb ^ diff);
            expect_eq("R8 code-bit kind", 32'(kind_a), 32'd2);
            expect_eq("R8 code-bit no flip", 32'({eb_a, em_a}), 32'd0);
        end

        // Two-bit differences
        for (int i = 0; i < 24; i++) begin
            for (int j = i + 1; j < 24; j++) begin
                diff = (24'd1 << i) | (24'd1 << j);
                do_check(ca ^ diff, cb ^ diff);
                expect_eq("R9 double kind", 32'(kind_a), 32'd3);
                expect_eq("R9 double no flip", 32'({eb_a, em_a}), 32'd0);
            end
        end
        do_check(~ca, ~cb);
        expect_eq("R9 all-ones difference", 32'(kind_a), 32'd3);

        // Real data flips through the stream
        stream(NA, 137, 5, 1'b0, -5);
        do_check(ca, cb);
        expect_eq("R6 real flip kind", 32'(kind_a), 32'd1);
        expect_eq("R6 real flip byte", 32'(eb_a), 32'd137);
        expect_eq("R6 real flip mask", 32'(em_a), 32'h20);
        expect_eq("R6 small real flip byte", 32'(eb_b), 32'd137);
        stream(NA, 511, 7, 1'b0, -5);
        do_check(ca, cb);
        expect_eq("R6 last bit byte", 32'(eb_a), 32'd511);
        expect_eq("R6 last bit mask", 32'(em_a), 32'h80);
        expect_eq("R4 small unaffected by late flip", 32'(kind_b), 32'd0);
        stream(NA, 0, 0, 1'b0, -5);
        do_check(ca, cb);
        expect_eq("R6 first bit kind", 32'(kind_a), 32'd1);
        expect_eq("R6 first bit mask", 32'({eb_a, em_a}), 32'h01);

        // Restart mid-sector, with a strobe during accumulation
        stream(100, 50, 3, 1'b0, 10);
        expect_eq("R3 partial not valid", 32'(cv_a), 32'd0);
        stream(NA, -1, 0, 1'b0, -5);
        expect_eq("R3 restart code", 32'(code_a), 32'(ca));
        expect_eq("R3 restart small code", 32'(code_b), 32'(cb));
        @(negedge clk);
        sos = 1'b1;
        @(negedge clk);
        sos = 1'b0;
        expect_eq("R3 sos drops code_valid", 32'(cv_a), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule